// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block decides when a five-stage in-order integer pipeline must pause because of a load. It looks at the instruction that has just been decoded and the instruction in the execute stage. A load cannot deliver its data until the end of the memory stage. So if the next instruction needs that data, forwarding cannot help in the next cycle. In that case the unit freezes the program counter and the fetch/decode register for one cycle, and it puts an empty slot into the decode/execute register. Once the load reaches the memory/writeback register, the dependent instruction moves on and picks up the value through forwarding.

The stall logic comes with a small set of pipeline registers that carry the register fields and the main control word down the pipe. The control word is produced in decode. The stage registers are fetch/decode, decode/execute, execute/memory and memory/writeback. The destination register is chosen in execute and travels with the instruction up to writeback. The program counter, the forwarding muxes, the ALU and the memories sit outside the block. The block drives the program counter's write enable.

The control word is 9 bits wide and uses this layout:

| Bit | Field |
|---|---|
| 8 | rd-selects-destination |
| 7:6 | ALU operation class |
| 5 | immediate operand |
| 4 | memory read |
| 3 | memory write |
| 2 | branch |
| 1 | register write |
| 0 | memory-to-register |

Top module: `load_use_stall_unit`

## Requirements
- R1: While rstN is low, every pipeline register is cleared to zero. In that state stall is 0, pcWrite is 1 and ifIdWrite is 1.
- R2: stall is 1 exactly when all three of these hold:
  - bit 4 (memory read) of exCtrl is set;
  - exRt is not 0;
  - exRt equals decRs or decRt.
- R3: While stall is 1, pcWrite and ifIdWrite are 0. On the following edge, the fetch/decode register keeps its contents (decRs and decRt do not change) whatever the fetch inputs carry.
- R4: On an edge where stall is 1, the decode/execute register is loaded with all zeros. After that edge, exCtrl, exRs and exRt read 0.
- R5: A load whose destination field (exRt) is register 0 never causes a stall, even when decRs or decRt is 0.
- R6: No stall occurs when the execute-stage instruction does not read memory. This covers ALU, store and branch instructions, even when they name the same registers as the decode-stage instruction. It also covers back-to-back independent loads.
- R7: A stall lasts exactly one cycle. The cycle after a stall always has stall equal to 0.
- R8: Without a stall, each pipeline register takes its predecessor's value on every edge:
  - fields and control move one stage per cycle;
  - the destination chosen in execute is exRd-style rd when bit 8 is set, and rt otherwise;
  - that destination appears on memDest one cycle later and on wbDest two cycles later.
- R9: Two cycles after a stall, the dependent instruction is in execute and the load is in memory/writeback. At that point wbMemToReg is 1, and wbDest equals exRs or exRt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchRs | input | 5 | rs field of the fetched instruction |
| fetchRt | input | 5 | rt field of the fetched instruction |
| fetchRd | input | 5 | rd field of the fetched instruction |
| fetchCtrl | input | 9 | Main control word for the fetched instruction |
| pcWrite | output | 1 | Program counter write enable |
| ifIdWrite | output | 1 | Fetch/decode register write enable |
| stall | output | 1 | Load-use stall, and bubble into decode/execute |
| decRs | output | 5 | rs held in fetch/decode |
| decRt | output | 5 | rt held in fetch/decode |
| exCtrl | output | 9 | Control word in decode/execute |
| exRs | output | 5 | rs in decode/execute |
| exRt | output | 5 | rt in decode/execute |
| memDest | output | 5 | Destination in execute/memory |
| memRegWrite | output | 1 | Register write flag in execute/memory |
| wbDest | output | 5 | Destination in memory/writeback |
| wbRegWrite | output | 1 | Register write flag in memory/writeback |
| wbMemToReg | output | 1 | Memory-to-register flag in memory/writeback |

## Verification
Two things can happen in the same cycle:
- the unit inserts a bubble and holds fetch/decode;
- an older load drains from execute/memory into memory/writeback.

The directed sequence provokes this with two loads in a row where the second load's successor reads the second load's destination. The bench then checks three things:
- only the second pair stalls;
- the first load's destination still arrives at wbDest on schedule;
- the dependent instruction reaches execute with the second load sitting in memory/writeback.

Random streams over a small register range produce many more such overlaps. Each one is judged cycle by cycle against a stage model in the bench.

// File: rtl/lus_pkg.sv
package lus_pkg;
  localparam int REG_W  = 5;
  localparam int CTRL_W = 9;

  typedef struct packed {
    logic       regDst;
    logic [1:0] aluOp;
    logic       aluSrc;
    logic       memRead;
    logic       memWrite;
    logic       branch;
    logic       regWrite;
    logic       memToReg;
  } ctrl_t;

  typedef struct packed {
    logic pcWrite;
    logic ifIdWrite;
    logic bubble;
  } strobe_t;
endpackage

// File: rtl/lus_control.sv
module lus_control
  import lus_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic          exMemRead,
  input  logic [RW-1:0] exRt,
  input  logic [RW-1:0] decRs,
  input  logic [RW-1:0] decRt,
  output strobe_t       strb
);
  localparam logic [RW-1:0] ZERO_REG = '0;

  logic hitRs;
  logic hitRt;
  logic loadUse;

  always_comb begin
    hitRs   = (exRt == decRs);
    hitRt   = (exRt == decRt);
    loadUse = exMemRead && (exRt != ZERO_REG) && (hitRs || hitRt);
    strb.pcWrite   = !loadUse;
    strb.ifIdWrite = !loadUse;
    strb.bubble    = loadUse;
  end
endmodule

// File: rtl/lus_datapath.sv
module lus_datapath
  import lus_pkg::*;
#(
  parameter int RW = REG_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [RW-1:0] fetchRs,
  input  logic [RW-1:0] fetchRt,
  input  logic [RW-1:0] fetchRd,
  input  ctrl_t         fetchCtrl,
  output logic [RW-1:0] decRs,
  output logic [RW-1:0] decRt,
  output ctrl_t         exCtrl,
  output logic [RW-1:0] exRs,
  output logic [RW-1:0] exRt,
  output ctrl_t         memCtrl,
  output logic [RW-1:0] memDest,
  output ctrl_t         wbCtrl,
  output logic [RW-1:0] wbDest
);
  logic [RW-1:0] decRd;
  ctrl_t         decCtrl;
  logic [RW-1:0] exRd;
  logic [RW-1:0] exDest;

  // fetch/decode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      decRs <= '0; decRt <= '0; decRd <= '0; decCtrl <= '0;
    end else if (strb.ifIdWrite) begin
      decRs <= fetchRs; decRt <= fetchRt; decRd <= fetchRd; decCtrl <= fetchCtrl;
    end
  end

  // decode/execute, bubble clears the whole slot
  always_ff @(posedge clk) begin
    if (!rstN || strb.bubble) begin
      exCtrl <= '0; exRs <= '0; exRt <= '0; exRd <= '0;
    end else begin
      exCtrl <= decCtrl; exRs <= decRs; exRt <= decRt; exRd <= decRd;
    end
  end

  assign exDest = exCtrl.regDst ? exRd : exRt;

  // execute/memory and memory/writeback
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memCtrl <= '0; memDest <= '0; wbCtrl <= '0; wbDest <= '0;
    end else begin
      memCtrl <= exCtrl;  memDest <= exDest;
      wbCtrl  <= memCtrl; wbDest  <= memDest;
    end
  end
endmodule

// File: rtl/load_use_stall_unit.sv
module load_use_stall_unit
  import lus_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int CW = CTRL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [RW-1:0] fetchRs,
  input  logic [RW-1:0] fetchRt,
  input  logic [RW-1:0] fetchRd,
  input  logic [CW-1:0] fetchCtrl,
  output logic          pcWrite,
  output logic          ifIdWrite,
  output logic          stall,
  output logic [RW-1:0] decRs,
  output logic [RW-1:0] decRt,
  output logic [CW-1:0] exCtrl,
  output logic [RW-1:0] exRs,
  output logic [RW-1:0] exRt,
  output logic [RW-1:0] memDest,
  output logic          memRegWrite,
  output logic [RW-1:0] wbDest,
  output logic          wbRegWrite,
  output logic          wbMemToReg
);
  strobe_t strb;
  ctrl_t   exCtrlS;
  ctrl_t   memCtrlS;
  ctrl_t   wbCtrlS;

  lus_control #(.RW(RW)) u_ctrl (
    .exMemRead(exCtrlS.memRead), .exRt(exRt),
    .decRs(decRs), .decRt(decRt), .strb(strb)
  );

  lus_datapath #(.RW(RW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .fetchRs(fetchRs), .fetchRt(fetchRt), .fetchRd(fetchRd),
    .fetchCtrl(ctrl_t'(fetchCtrl)),
    .decRs(decRs), .decRt(decRt),
    .exCtrl(exCtrlS), .exRs(exRs), .exRt(exRt),
    .memCtrl(memCtrlS), .memDest(memDest),
    .wbCtrl(wbCtrlS), .wbDest(wbDest)
  );

  assign pcWrite     = strb.pcWrite;
  assign ifIdWrite   = strb.ifIdWrite;
  assign stall       = strb.bubble;
  assign exCtrl      = exCtrlS;
  assign memRegWrite = memCtrlS.regWrite;
  assign wbRegWrite  = wbCtrlS.regWrite;
  assign wbMemToReg  = wbCtrlS.memToReg;
endmodule

// File: rtl/lus_checker.sv
module lus_checker #(
  parameter int RW = 5,
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rstN,
  input logic          pcWrite,
  input logic          ifIdWrite,
  input logic          stall,
  input logic [RW-1:0] decRs,
  input logic [RW-1:0] decRt,
  input logic [CW-1:0] exCtrl,
  input logic [RW-1:0] exRs,
  input logic [RW-1:0] exRt,
  input logic [RW-1:0] wbDest,
  input logic          wbMemToReg
);
  // R3
  freeze_front_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (!pcWrite && !ifIdWrite));
  // R3
  hold_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ($stable(decRs) && $stable(decRt)));
  // R4
  bubble_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (exCtrl == '0 && exRt == '0 && exRs == '0));
  // R7
  single_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall);
  // R5
  no_zero_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (exRt == '0) |-> !stall);
  // R6
  no_load_no_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !exCtrl[4] |-> !stall);
  // R8
  advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && $past(rstN)) |=> (exRs == $past(decRs) && exRt == $past(decRt)));
  // R9
  handoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stall, 2) && $past(rstN, 2)) |->
      (wbMemToReg && (wbDest == exRs || wbDest == exRt)));
endmodule

bind load_use_stall_unit lus_checker #(.RW(RW), .CW(CW)) u_chk (.*);

// File: tb/load_use_stall_unit_bench.sv
module load_use_stall_unit_bench;
  typedef struct packed {
    logic [4:0] rs;
    logic [4:0] rt;
    logic [4:0] rd;
    logic [8:0] ctrl;
  } instr_t;

  localparam logic [8:0] C_LW  = 9'b0_00_1_1_0_0_1_1;
  localparam logic [8:0] C_ALU = 9'b1_10_0_0_0_0_1_0;
  localparam logic [8:0] C_SW  = 9'b0_00_1_0_1_0_0_0;
  localparam logic [8:0] C_BEQ = 9'b0_01_0_0_0_1_0_0;
  localparam int N_PROG = 320;

  logic clk = 0;
  logic rstN = 0;
  logic [4:0] fetchRs = 0, fetchRt = 0, fetchRd = 0;
  logic [8:0] fetchCtrl = 0;
  logic pcWrite, ifIdWrite, stall, memRegWrite, wbRegWrite, wbMemToReg;
  logic [4:0] decRs, decRt, exRs, exRt, memDest, wbDest;
  logic [8:0] exCtrl;

  always #2 clk = ~clk;

  load_use_stall_unit u_load_use_stall_unit (
    .clk(clk), .rstN(rstN), .fetchRs(fetchRs), .fetchRt(fetchRt),
    .fetchRd(fetchRd), .fetchCtrl(fetchCtrl), .pcWrite(pcWrite),
    .ifIdWrite(ifIdWrite), .stall(stall), .decRs(decRs), .decRt(decRt),
    .exCtrl(exCtrl), .exRs(exRs), .exRt(exRt), .memDest(memDest),
    .memRegWrite(memRegWrite), .wbDest(wbDest), .wbRegWrite(wbRegWrite),
    .wbMemToReg(wbMemToReg)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  instr_t prog [N_PROG];
  instr_t mIfid, mIdex, mExmem, mMemwb, drv;
  int pc;
  bit prevStall, prev2Stall, expStall;

  function automatic instr_t mk(logic [8:0] c, int s, int t, int d);
    instr_t i;
    i.rs = 5'(s); i.rt = 5'(t); i.rd = 5'(d); i.ctrl = c;
    return i;
  endfunction

  function automatic bit hz(instr_t ex, instr_t id);
    return ex.ctrl[4] && ex.rt != 0 && (ex.rt == id.rs || ex.rt == id.rt);
  endfunction

  function automatic logic [4:0] dst(instr_t i);
    return i.ctrl[8] ? i.rd : i.rt;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int k;
    void'($urandom(32'd2024));
    k = 0;
    // load-use on rs
    prog[k++] = mk(C_LW, 1, 5, 0);  prog[k++] = mk(C_ALU, 5, 2, 3);
    // load to register 0 followed by reader of 0
    prog[k++] = mk(C_LW, 2, 0, 0);  prog[k++] = mk(C_ALU, 0, 0, 4);
    // back-to-back independent loads
    prog[k++] = mk(C_LW, 6, 3, 0);  prog[k++] = mk(C_LW, 6, 4, 0);
    // load then independent ALU
    prog[k++] = mk(C_LW, 1, 7, 0);  prog[k++] = mk(C_ALU, 8, 9, 10);
    // ALU writing rt reused next: no memory read
    prog[k++] = mk(C_ALU, 1, 2, 2); prog[k++] = mk(C_ALU, 2, 2, 5);
    // two loads, successor of second uses it on rt (overlap of stall and drain)
    prog[k++] = mk(C_LW, 1, 11, 0); prog[k++] = mk(C_LW, 1, 12, 0);
    prog[k++] = mk(C_SW, 3, 12, 0);
    prog[k++] = mk(C_ALU, 11, 1, 6);
    while (k < N_PROG) begin
      int op = int'($urandom % 4);
      int s = int'($urandom % 8), t = int'($urandom % 8), d = int'($urandom % 8);
      case (op)
        0: prog[k] = mk(C_LW, s, t, d);
        1: prog[k] = mk(C_ALU, s, t, d);
        2: prog[k] = mk(C_SW, s, t, d);
        default: prog[k] = mk(C_BEQ, s, t, d);
      endcase
      k++;
    end

    mIfid = '0; mIdex = '0; mExmem = '0; mMemwb = '0;
    pc = 0; prevStall = 0; prev2Stall = 0;
    repeat (3) @(negedge clk);
    chk(stall == 0, "R1", "stall in reset", int'(stall), 0);
    chk(pcWrite == 1 && ifIdWrite == 1, "R1", "write enables in reset", int'({pcWrite, ifIdWrite}), 3);
    chk(exCtrl == 0 && decRs == 0 && decRt == 0, "R1", "stage regs in reset", int'(exCtrl), 0);
    chk(wbDest == 0 && memDest == 0 && !wbRegWrite, "R1", "late regs in reset", int'(wbDest), 0);
    rstN = 1;

    for (int cyc = 0; cyc < N_PROG + 60; cyc++) begin
      string sTag;
      expStall = hz(mIdex, mIfid);
      if (expStall) sTag = "R2";
      else if (prevStall) sTag = "R7";
      else if (mIdex.ctrl[4]) sTag = "R5";
      else sTag = "R6";
      if (mIdex.ctrl[4] && mIdex.rt == 0) sTag = "R5";
      chk(stall == expStall, sTag, "stall", int'(stall), int'(expStall));
      chk(pcWrite == !expStall && ifIdWrite == !expStall, "R3", "pcWrite/ifIdWrite",
          int'({pcWrite, ifIdWrite}), expStall ? 0 : 3);
      chk(decRs == mIfid.rs && decRt == mIfid.rt, prevStall ? "R3" : "R8", "decode fields",
          int'({decRs, decRt}), int'({mIfid.rs, mIfid.rt}));
      chk(exCtrl == mIdex.ctrl && exRt == mIdex.rt && exRs == mIdex.rs,
          prevStall ? "R4" : "R8", "execute slot", int'(exCtrl), int'(mIdex.ctrl));
      chk(memDest == dst(mExmem) && memRegWrite == mExmem.ctrl[1], "R8", "memDest",
          int'(memDest), int'(dst(mExmem)));
      chk(wbDest == dst(mMemwb) && wbMemToReg == mMemwb.ctrl[0] && wbRegWrite == mMemwb.ctrl[1],
          "R8", "wbDest", int'(wbDest), int'(dst(mMemwb)));
      if (prev2Stall)
        chk(wbMemToReg && (wbDest == exRs || wbDest == exRt), "R9", "load handoff",
            int'(wbDest), int'(exRs));

      if (expStall) drv = instr_t'($urandom);
      else if (pc < N_PROG) drv = prog[pc];
      else drv = '0;
      fetchRs = drv.rs; fetchRt = drv.rt; fetchRd = drv.rd; fetchCtrl = drv.ctrl;

      @(posedge clk);
      mMemwb = mExmem;
      mExmem = mIdex;
      mIdex = expStall ? instr_t'('0) : mIfid;
      if (!expStall) begin
        mIfid = drv;
        pc++;
      end
      prev2Stall = prevStall;
      prevStall = expStall;
      @(negedge clk);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule